// File: doc/BRIEF.md
# Flooding Min-Sum LDPC Decoder Controller

This block decodes one received word of a small LDPC code with eight coded bits and four parity checks. The check connections come from a 4×8 connection matrix. A `start` pulse latches that matrix and arms the decoder. The eight signed channel reliabilities are sampled in the first channel phase. After that the block runs flooding min-sum message passing, and it keeps every per-edge message in both directions in its own registers.

Each iteration walks four phases in a fixed order: channel evidence, variable-to-check, check-to-variable, then decide. The decide phase forms the hard-decision word and the syndrome. Phases advance either one per `step` pulse or one per clock while `run` is held. Decoding stops on an all-zero syndrome (converged) or when the iteration limit is reached (not converged).

There is no streaming handshake. The matrix and reliabilities are plain levels, sampled at fixed moments: the matrix at `start`, the reliabilities in the first channel phase. Nothing upstream is ever back-pressured. The caller must hold them stable only until those moments.

Top module: `ldpc_minsum_flood`

## Requirements
- R1: After reset, and in the cycle after any `start` pulse, `hard_bits`, `syndrome`, `iter_count`, `done` and `converged` are zero and `phase` is 0. After reset `busy` is 0; after `start` `busy` is 1.
- R2: `phase` names the next phase to run: 0 channel evidence, 1 variable-to-check, 2 check-to-variable, 3 decide. It goes 0,1,2,3 and back to 0. It also returns to 0 when decoding stops.
- R3: With `run` low, each cycle in which `step` is high advances exactly one phase. Cycles with both low change nothing.
- R4: With `run` high, one phase advances per clock, so a decode of k iterations raises `done` exactly 4·k clock edges after the `start` edge.
- R5: The matrix `h_matrix` is latched at `start`. The reliabilities `llr_in` (bit v at `llr_in[6v+:6]`, two's complement, positive favours 0) are sampled only in the first iteration's channel phase. Later changes to either input do not alter the result.
- R6: In the first iteration each edge carries the variable's channel value. Later, an edge carries the channel value plus all incoming check messages except that edge's own, saturated to ±(2^(MSG_W−1)−1).
- R7: A check-to-variable message carries the product of the signs of the other edges' messages and the smallest of their magnitudes. It is zero when no other edge exists. Positions without an edge (`h_matrix[c*8+v]` = 0) carry nothing.
- R8: In the decide phase, bit v of `hard_bits` is 1 only when the channel value plus all incoming check messages is negative. A total of exactly zero decides 0.
- R9: Syndrome bit c is the XOR of the hard bits v for which `h_matrix[c*8+v]` is 1.
- R10: `iter_count` counts completed decide phases. A zero syndrome sets `done` and `converged`. Reaching MAX_ITER (default 8) with a nonzero syndrome sets `done` with `converged` low.
- R11: While `busy` is low, `step` and `run` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch matrix, clear results, arm the decoder |
| step | input | 1 | Advance one phase per high cycle |
| run | input | 1 | Advance one phase every clock while high |
| h_matrix | input | 32 | Connection matrix, bit c*8+v links check c to bit v |
| llr_in | input | 48 | Eight 6-bit signed channel reliabilities |
| hard_bits | output | 8 | Hard-decision word from the last decide phase |
| syndrome | output | 4 | Parity-check result of `hard_bits` |
| phase | output | 2 | Next phase to execute |
| iter_count | output | 4 | Completed iterations |
| busy | output | 1 | Decoder armed and not yet stopped |
| done | output | 1 | Decoding stopped |
| converged | output | 1 | Stopped on an all-zero syndrome |

## Verification
A corrupted stored message in either direction shows up no earlier than the next decide phase. It appears as a wrong bit in `hard_bits`, a syndrome bit that does not match that word, or a changed iteration count, so a fault can hide for up to three phases. A fault in the phase sequencer shows at once, as a wrong `phase` value or as `done` rising off the 4·k-edge schedule. The vectors include a word with one weak error that must be corrected in a single iteration. They also include a matrix with a single-edge check that can never be satisfied, which drives the decoder into the iteration limit.

// File: rtl/ldpc_mp_pkg.sv
package ldpc_mp_pkg;

  typedef enum logic [1:0] {
    PH_CHAN = 2'd0,
    PH_V2C  = 2'd1,
    PH_C2V  = 2'd2,
    PH_DEC  = 2'd3
  } phase_e;

endpackage

// File: rtl/ldpc_var_node.sv
module ldpc_var_node #(
  parameter int NC    = 4,
  parameter int LLR_W = 6,
  parameter int MSG_W = 8,
  parameter int TW    = 12
) (
  input  logic [LLR_W-1:0]    chan,
  input  logic [NC*MSG_W-1:0] c2v_col,
  input  logic [NC-1:0]       mask_col,
  output logic [TW-1:0]       total,
  output logic [NC*MSG_W-1:0] ext_col
);

  localparam logic signed [TW-1:0] PMAX = TW'((1 << (MSG_W-1)) - 1);
  localparam logic signed [TW-1:0] NMAX = -PMAX;

  function automatic logic [MSG_W-1:0] clip(input logic signed [TW-1:0] x);
    if (x > PMAX)      return PMAX[MSG_W-1:0];
    else if (x < NMAX) return NMAX[MSG_W-1:0];
    else               return x[MSG_W-1:0];
  endfunction

  logic signed [TW-1:0] acc;

  always_comb begin
    logic signed [TW-1:0] d;
    logic [MSG_W-1:0]     m;
    acc = {{(TW-LLR_W){chan[LLR_W-1]}}, chan};
    for (int c = 0; c < NC; c++) begin
      m = c2v_col[c*MSG_W +: MSG_W];
      if (mask_col[c]) acc = acc + {{(TW-MSG_W){m[MSG_W-1]}}, m};
    end
    for (int c = 0; c < NC; c++) begin
      m = c2v_col[c*MSG_W +: MSG_W];
      d = acc - {{(TW-MSG_W){m[MSG_W-1]}}, m};
      ext_col[c*MSG_W +: MSG_W] = mask_col[c] ? clip(d) : '0;
    end
  end

  assign total = acc;

endmodule

// File: rtl/ldpc_chk_node.sv
module ldpc_chk_node #(
  parameter int NV    = 8,
  parameter int MSG_W = 8
) (
  input  logic [NV*MSG_W-1:0] v2c_row,
  input  logic [NV-1:0]       mask_row,
  output logic [NV*MSG_W-1:0] c2v_row
);

  localparam logic [MSG_W-1:0] MAXMAG = MSG_W'((1 << (MSG_W-1)) - 1);

  always_comb begin
    logic             neg, any;
    logic [MSG_W-1:0] mn, m, a;
    for (int t = 0; t < NV; t++) begin
      neg = 1'b0;
      any = 1'b0;
      mn  = MAXMAG;
      for (int v = 0; v < NV; v++) begin
        m = v2c_row[v*MSG_W +: MSG_W];
        a = m[MSG_W-1] ? (~m) + MSG_W'(1) : m;
        if (v != t && mask_row[v]) begin
          any = 1'b1;
          neg = neg ^ m[MSG_W-1];
          if (a < mn) mn = a;
        end
      end
      if (mask_row[t] && any)
        c2v_row[t*MSG_W +: MSG_W] = neg ? (~mn) + MSG_W'(1) : mn;
      else
        c2v_row[t*MSG_W +: MSG_W] = '0;
    end
  end

endmodule

// File: rtl/ldpc_minsum_flood.sv
module ldpc_minsum_flood
  import ldpc_mp_pkg::*;
#(
  parameter int NV       = 8,
  parameter int NC       = 4,
  parameter int LLR_W    = 6,
  parameter int MSG_W    = 8,
  parameter int MAX_ITER = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          step,
  input  logic                          run,
  input  logic [NC*NV-1:0]              h_matrix,
  input  logic [NV*LLR_W-1:0]           llr_in,
  output logic [NV-1:0]                 hard_bits,
  output logic [NC-1:0]                 syndrome,
  output logic [1:0]                    phase,
  output logic [$clog2(MAX_ITER+1)-1:0] iter_count,
  output logic                          busy,
  output logic                          done,
  output logic                          converged
);

  localparam int IW    = $clog2(MAX_ITER+1);
  localparam int TW    = MSG_W + $clog2(NC+1) + 1;
  localparam int EDGES = NC * NV;
  localparam logic [MSG_W-1:0] MSG_MIN = {1'b1, {(MSG_W-1){1'b0}}};

  phase_e                 ph_q;
  logic [EDGES-1:0]       h_q;
  logic [NV*LLR_W-1:0]    chan_q;
  logic [EDGES*MSG_W-1:0] v2c_q, c2v_q, v2c_nxt, c2v_nxt;
  logic [NV*TW-1:0]       tot_all;
  logic [NV-1:0]          hard_q, hard_nxt;
  logic [NC-1:0]          syn_q, syn_nxt;
  logic [IW-1:0]          iter_q;
  logic                   busy_q, done_q, conv_q, adv;

  // one variable unit per coded bit; matrix column c*NV+v gathered per bit
  for (genvar v = 0; v < NV; v++) begin : g_var
    logic [NC*MSG_W-1:0] col_c2v, col_ext;
    logic [NC-1:0]       col_mask;
    for (genvar c = 0; c < NC; c++) begin : g_col
      assign col_c2v[c*MSG_W +: MSG_W]            = c2v_q[(c*NV+v)*MSG_W +: MSG_W];
      assign col_mask[c]                          = h_q[c*NV+v];
      assign v2c_nxt[(c*NV+v)*MSG_W +: MSG_W]     = col_ext[c*MSG_W +: MSG_W];
    end
    ldpc_var_node #(.NC(NC), .LLR_W(LLR_W), .MSG_W(MSG_W), .TW(TW)) u_var (
      .chan     (chan_q[v*LLR_W +: LLR_W]),
      .c2v_col  (col_c2v),
      .mask_col (col_mask),
      .total    (tot_all[v*TW +: TW]),
      .ext_col  (col_ext)
    );
    assign hard_nxt[v] = tot_all[v*TW + TW-1];
  end

  // one check unit per parity row
  for (genvar c = 0; c < NC; c++) begin : g_chk
    ldpc_chk_node #(.NV(NV), .MSG_W(MSG_W)) u_chk (
      .v2c_row  (v2c_q[c*NV*MSG_W +: NV*MSG_W]),
      .mask_row (h_q[c*NV +: NV]),
      .c2v_row  (c2v_nxt[c*NV*MSG_W +: NV*MSG_W])
    );
    assign syn_nxt[c] = ^(h_q[c*NV +: NV] & hard_nxt);
  end

  assign adv = busy_q && !start && (run || step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_CHAN;
      h_q    <= '0;
      chan_q <= '0;
      v2c_q  <= '0;
      c2v_q  <= '0;
      hard_q <= '0;
      syn_q  <= '0;
      iter_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      conv_q <= 1'b0;
    end else if (start) begin
      ph_q   <= PH_CHAN;
      h_q    <= h_matrix;
      hard_q <= '0;
      syn_q  <= '0;
      iter_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
      conv_q <= 1'b0;
    end else if (adv) begin
      unique case (ph_q)
        PH_CHAN: begin
          if (iter_q == '0) begin
            chan_q <= llr_in;
            c2v_q  <= '0;
          end
          ph_q <= PH_V2C;
        end
        PH_V2C: begin
          v2c_q <= v2c_nxt;
          ph_q  <= PH_C2V;
        end
        PH_C2V: begin
          c2v_q <= c2v_nxt;
          ph_q  <= PH_DEC;
        end
        PH_DEC: begin
          hard_q <= hard_nxt;
          syn_q  <= syn_nxt;
          iter_q <= iter_q + IW'(1);
          ph_q   <= PH_CHAN;
          if (syn_nxt == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            conv_q <= 1'b1;
          end else if (iter_q + IW'(1) == IW'(MAX_ITER)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: ph_q <= PH_CHAN;
      endcase
    end
  end

  assign hard_bits  = hard_q;
  assign syndrome   = syn_q;
  assign phase      = ph_q;
  assign iter_count = iter_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign converged  = conv_q;

  AST_PHASE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ph_q != PH_DEC) |=> (phase == $past(phase) + 2'd1)); // R2
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && !run && !step) |=> ($stable(phase) && $stable(iter_count))); // R3
  AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> ($stable(hard_bits) && $stable(iter_count) && $stable(done))); // R11
  AST_CONV_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    converged |-> (syndrome == '0 && done && !busy)); // R10
  AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    iter_count <= IW'(MAX_ITER)); // R10

  for (genvar e = 0; e < EDGES; e++) begin : g_edge_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      v2c_q[e*MSG_W +: MSG_W] != MSG_MIN); // R6
    AST_NON_EDGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (iter_q != '0 && !h_q[e]) |-> (c2v_q[e*MSG_W +: MSG_W] == '0)); // R7
  end

endmodule

// File: tb/test_ldpc_minsum_flood.sv
module test_ldpc_minsum_flood;

  logic        clk = 1'b0;
  logic        rst_n, start, step, run;
  logic [31:0] h_matrix;
  logic [47:0] llr_in;
  logic [7:0]  hard_bits;
  logic [3:0]  syndrome;
  logic [1:0]  phase;
  logic [3:0]  iter_count;
  logic        busy, done, converged;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ldpc_minsum_flood i_ldpc_minsum_flood (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .run(run),
    .h_matrix(h_matrix), .llr_in(llr_in), .hard_bits(hard_bits),
    .syndrome(syndrome), .phase(phase), .iter_count(iter_count),
    .busy(busy), .done(done), .converged(converged)
  );

  typedef struct packed {
    logic [31:0]      h;
    logic [0:7][5:0]  llr;
    logic [7:0]       hard;
    logic [3:0]       syn;
    logic             conv;
    logic [3:0]       iter;
  } vec_t;

  localparam logic [31:0] HA = 32'h894C2613; // c0:v0v1v4 c1:v1v2v5 c2:v2v3v6 c3:v0v3v7
  localparam logic [31:0] HB = 32'h80300C03; // c3 touches only v7

  localparam vec_t VECS [0:4] = '{
    '{HA, '{6'h04,6'h04,6'h04,6'h04,6'h04,6'h04,6'h04,6'h04}, 8'h00, 4'h0, 1'b1, 4'd1},
    '{HA, '{6'h3E,6'h06,6'h06,6'h06,6'h06,6'h06,6'h06,6'h06}, 8'h00, 4'h0, 1'b1, 4'd1},
    '{HB, '{6'h05,6'h05,6'h05,6'h05,6'h05,6'h05,6'h05,6'h3B}, 8'h80, 4'h8, 1'b0, 4'd8},
    '{32'h0, '{6'h3C,6'h04,6'h04,6'h3C,6'h3C,6'h00,6'h3C,6'h04}, 8'h59, 4'h0, 1'b1, 4'd1},
    '{HA, '{6'h3C,6'h04,6'h04,6'h3C,6'h3C,6'h04,6'h3C,6'h04}, 8'h59, 4'h0, 1'b1, 4'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  function automatic logic [47:0] pack_llr(input logic [0:7][5:0] l);
    logic [47:0] r;
    for (int v = 0; v < 8; v++) r[v*6 +: 6] = l[v];
    return r;
  endfunction

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL R4: watchdog expired, actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; step = 1'b0; run = 1'b0;
    h_matrix = '0; llr_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 reset phase", 32'(phase), 0);
    check("R1 reset flags", {busy, done, converged}, 0);
    check("R1 reset results", {hard_bits, syndrome, iter_count}, 0);

    // table walk in run mode: R4 timing, R6/R7 messages, R8/R9/R10 results
    run = 1'b1;
    for (int i = 0; i < 5; i++) begin
      int cyc;
      h_matrix = VECS[i].h;
      llr_in   = pack_llr(VECS[i].llr);
      pulse_start();
      cyc = 0;
      while (!done && cyc < 200) begin
        @(negedge clk);
        cyc++;
      end
      check("R4 cycles to done", cyc, 4 * int'(VECS[i].iter));
      check("R8 R6 R7 hard word", hard_bits, VECS[i].hard);
      check("R9 syndrome", syndrome, VECS[i].syn);
      check("R10 converged", converged, VECS[i].conv);
      check("R10 iterations", iter_count, VECS[i].iter);
      check("R2 phase at stop", phase, 0);
    end
    run = 1'b0;

    // R3/R5: step mode, inputs changed after sampling
    h_matrix = 32'h0;
    llr_in   = pack_llr(VECS[3].llr);
    pulse_start();
    check("R1 start busy", {busy, done, converged}, 3'b100);
    check("R1 start phase", phase, 0);
    repeat (3) @(negedge clk);
    check("R3 hold without step", phase, 0);
    pulse_step();
    check("R2 R3 phase after 1 step", phase, 1);
    h_matrix = HA;
    llr_in   = pack_llr(VECS[0].llr);
    pulse_step();
    check("R2 phase after 2 steps", phase, 2);
    pulse_step();
    check("R2 phase after 3 steps", phase, 3);
    check("R1 hard before decide", hard_bits, 0);
    repeat (2) @(negedge clk);
    check("R3 hold in phase 3", {phase, done}, 3'b110);
    pulse_step();
    check("R5 inputs ignored after sampling", hard_bits, 8'h59);
    check("R10 step decode converged", {done, converged, busy}, 3'b110);
    check("R10 step decode iterations", iter_count, 1);

    // R11: controls ignored when not busy
    pulse_step();
    run = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b0;
    check("R11 idle result held", {hard_bits, syndrome}, {8'h59, 4'h0});
    check("R11 idle state held", {iter_count, done, busy, phase}, {4'd1, 1'b1, 1'b0, 2'd0});

    // R1: restart clears previous results
    pulse_start();
    check("R1 restart clears", {hard_bits, syndrome, iter_count, done, converged}, 0);
    check("R1 restart busy", busy, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule